// File: doc/BRIEF.md
# Daisy-Chain Conversion Readback Sequencer

This block runs a complete conversion-and-readback cycle over a chain of up to eight stacked cell-monitor devices on a shared serial link. It issues each command frame to an external serial PHY and collects the frame that comes back. In scan mode it sends two broadcast commands. The first points every device's read selector at cell channel 0. The second starts a conversion of all inputs, with readback of all results, triggered by chip select. The block then waits a conversion delay that it computes in hardware from the acquisition-time code, the averaging code and the chain length. After the wait it clocks out twelve result frames per device, sending the fixed filler word on each. Every received frame is checked against its 8-bit CRC and, if valid, passed to a downstream decoder.

In discovery mode the block counts the devices in the chain. It writes a software reset that also sets the address-lock and chain-readback bits, writes the same value again without the reset, and points the read selector at the low control register. It then reads frames until one arrives as all zeros. Each frame read before the zero frame must carry its own position as a bit-reversed 5-bit device address. The serial link runs in SPI mode 1 at no more than 700 kHz, but the PHY that produces it is outside this block.

Top module: `chain_scan_seq`

## Requirements
- R1: After reset, `xfer_req_o`, `busy_o`, `done_o` and `frame_valid_o` are low, `status_o` is 0 (OK) and `dev_found_o` is 0.
- R2: Command frames are laid out as follows: device address in [31:27], register in [26:21], data in [20:13], broadcast flag in [12], bit 11 zero, CRC in [10:3] and 3'b010 in [2:0]. The CRC covers bits [31:11]. In a scan, the first command targets register 0x1C with data 0x00 and the second targets register 0x0D with data {4'b0000, 1'b1, avg, 1'b0}. Both commands use device address 0 and broadcast 1. `xfer_tx_o` stays stable while `xfer_req_o` is high and `xfer_done_i` is low.
- R3: Let the cycle in which the done for the second scan command is sampled be cycle T. The first readback request then appears in cycle T+D, where D = (ceil(((tACQ+695)·12·2^avg − tACQ + 250·extra)/1000) + 5) · CLK_MHZ. tACQ is 465, 1010, 1460 or 1890 for acquisition codes 0 to 3.
- R4: A scan issues exactly (extra+1)·12 readback transfers, each sending 0xF800030A. One cycle after each transfer completes with a valid CRC, `frame_valid_o` pulses for one cycle with `frame_data_o` equal to the received word.
- R5: The CRC of a received frame is the remainder of bits [31:10] divided by x^8+x^5+x^3+x^2+x+1, and it must equal bits [9:2]. On a mismatch, the block forwards no frame, issues no further transfer, and ends with status 1 (CRC).
- R6: Discovery sends three broadcast commands to device 0. The first writes register 0x0E with data 0x95 | acq<<5. The second writes register 0x0E with data 0x15 | acq<<5. The third writes register 0x1C with data 0x38. Readback then starts without a wait, and no frame is forwarded to the decoder.
- R7: In discovery, let k be the index of the first all-zero frame. For k ≥ 1, the run ends with status 0 and `dev_found_o` = k−1. A zero frame at index 0, or nine non-zero frames in a row, ends the run with status 3 (chain fault). A non-zero frame whose reversed bits [31:27] differ from its index ends the run with status 2 (address).
- R8: A start strobe that arrives while `busy_o` is high is ignored. The run in progress keeps its mode, settings and transfer sequence.
- R9: `done_o` pulses high for exactly one cycle at the end of every run, and `busy_o` falls in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| discover_i | input | 1 | 1 = chain discovery, 0 = conversion scan |
| extra_dev_i | input | DEV_W | Number of devices beyond the first |
| acq_code_i | input | 2 | Acquisition-time code |
| avg_code_i | input | 2 | Averaging code (2^code conversions) |
| xfer_req_o | output | 1 | Request one 32-bit transfer from the PHY |
| xfer_tx_o | output | 32 | Word to transmit |
| xfer_done_i | input | 1 | Transfer complete, one-cycle pulse |
| xfer_rx_i | input | 32 | Word received, valid with `xfer_done_i` |
| frame_valid_o | output | 1 | Result frame for the decoder |
| frame_data_o | output | 32 | Result frame word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| status_o | output | 2 | 0 OK, 1 CRC, 2 address, 3 chain fault |
| dev_found_o | output | DEV_W | Extra devices found by discovery |

## Verification
The hardest cases to reach from the ports are the ones that depend on what the far end of the chain returns. These are a corrupted CRC partway through a long scan, a discovery frame that carries the wrong reversed address, and a chain that never produces the zero terminator. The bench's PHY model plays back a queue of received words that each test builds for its case. This lets a single flipped CRC bit, a swapped address, or nine non-zero frames be placed at an exact index. The wait delay is measured as the gap in cycles between the done of the second command and the first readback request, for the shortest and the longest settings. A second start strobe is injected during the wait to show that it changes nothing.

// File: rtl/chain_scan_pkg.sv
package chain_scan_pkg;

    localparam logic [31:0] READBACK_FILL = 32'hF800_030A;
    localparam logic [5:0]  REG_CTRL_HI   = 6'h0D;
    localparam logic [5:0]  REG_CTRL_LO   = 6'h0E;
    localparam logic [5:0]  REG_READ_SEL  = 6'h1C;
    localparam logic [7:0]  CRC_POLY      = 8'h2F;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_CRC   = 2'd1,
        ST_ADDR  = 2'd2,
        ST_CHAIN = 2'd3
    } seq_status_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_WAIT, S_READ, S_FINISH
    } seq_state_e;

    typedef struct packed {
        logic [4:0] dev;
        logic [5:0] regsel;
        logic [7:0] data;
        logic       bcast;
    } cmd_fields_t;

    // Polynomial remainder of a 24-bit value, MSB first.
    function automatic logic [7:0] crc8_rem(input logic [23:0] v);
        logic [7:0] r;
        logic       msb;
        r = '0;
        for (int i = 23; i >= 0; i--) begin
            msb = r[7];
            r   = {r[6:0], v[i]};
            if (msb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic logic [31:0] build_cmd(input cmd_fields_t f);
        logic [20:0] head;
        head = {f, 1'b0};
        return {head, crc8_rem({3'b000, head}), 3'b010};
    endfunction

    function automatic logic [4:0] rev5(input logic [4:0] a);
        return {a[0], a[1], a[2], a[3], a[4]};
    endfunction

endpackage

// File: rtl/seq_wait_calc.sv
module seq_wait_calc #(
    parameter int CLK_MHZ = 100,
    parameter int DEV_W   = 3,
    parameter int CNT_W   = 15
) (
    input  logic [1:0]       acq_i,
    input  logic [1:0]       avg_i,
    input  logic [DEV_W-1:0] extra_i,
    output logic [CNT_W-1:0] cycles_o
);
    logic [31:0] tacq_ns, conv_ns, total_ns, micro;

    always_comb begin
        unique case (acq_i)
            2'd0:    tacq_ns = 32'd465;
            2'd1:    tacq_ns = 32'd1010;
            2'd2:    tacq_ns = 32'd1460;
            default: tacq_ns = 32'd1890;
        endcase
        conv_ns  = ((tacq_ns + 32'd695) * 32'd12) << avg_i;
        total_ns = conv_ns - tacq_ns + 32'(extra_i) * 32'd250;
        micro    = (total_ns + 32'd999) / 32'd1000 + 32'd5;
        cycles_o = CNT_W'(micro * 32'(CLK_MHZ));
    end
endmodule

// File: rtl/seq_frame_check.sv
module seq_frame_check
    import chain_scan_pkg::*;
#(
    parameter int FRM_W = 7
) (
    input  logic [31:0]      rx_i,
    input  logic [FRM_W-1:0] index_i,
    output logic             crc_ok_o,
    output logic             zero_o,
    output logic             addr_ok_o
);
    always_comb begin
        crc_ok_o  = (crc8_rem({2'b00, rx_i[31:10]}) == rx_i[9:2]);
        zero_o    = (rx_i == '0);
        addr_ok_o = (FRM_W'(rev5(rx_i[31:27])) == index_i);
    end
endmodule

// File: rtl/chain_scan_seq.sv
module chain_scan_seq
    import chain_scan_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int MAX_DEV    = 8,
    parameter int CH_PER_DEV = 12,
    parameter int DEV_W      = $clog2(MAX_DEV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             discover_i,
    input  logic [DEV_W-1:0] extra_dev_i,
    input  logic [1:0]       acq_code_i,
    input  logic [1:0]       avg_code_i,
    output logic             xfer_req_o,
    output logic [31:0]      xfer_tx_o,
    input  logic             xfer_done_i,
    input  logic [31:0]      xfer_rx_i,
    output logic             frame_valid_o,
    output logic [31:0]      frame_data_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [DEV_W-1:0] dev_found_o
);
    localparam int FRM_W = $clog2(MAX_DEV * CH_PER_DEV + 1);
    localparam int CNT_W = $clog2(260 * CLK_MHZ + 1);

    seq_state_e       state;
    seq_status_e      status;
    logic [1:0]       cmd_idx;
    logic [FRM_W-1:0] frm;
    logic [CNT_W-1:0] cnt;
    logic             lat_disc;
    logic [DEV_W-1:0] lat_extra;
    logic [1:0]       lat_acq, lat_avg;
    logic [CNT_W-1:0] wait_cycles;
    logic             crc_ok, is_zero, addr_ok;
    logic [FRM_W-1:0] last_frm;
    logic [1:0]       last_cmd;
    cmd_fields_t      cmd;

    seq_wait_calc #(.CLK_MHZ(CLK_MHZ), .DEV_W(DEV_W), .CNT_W(CNT_W)) u_wait (
        .acq_i(lat_acq), .avg_i(lat_avg), .extra_i(lat_extra), .cycles_o(wait_cycles)
    );

    seq_frame_check #(.FRM_W(FRM_W)) u_check (
        .rx_i(xfer_rx_i), .index_i(frm),
        .crc_ok_o(crc_ok), .zero_o(is_zero), .addr_ok_o(addr_ok)
    );

    assign last_frm = FRM_W'((32'(lat_extra) + 32'd1) * 32'(CH_PER_DEV) - 32'd1);
    assign last_cmd = lat_disc ? 2'd2 : 2'd1;

    // Command table: scan uses entries 0..1, discovery 0..2.
    always_comb begin
        cmd.dev   = 5'd0;
        cmd.bcast = 1'b1;
        if (!lat_disc) begin
            cmd.regsel = (cmd_idx == 2'd0) ? REG_READ_SEL : REG_CTRL_HI;
            cmd.data   = (cmd_idx == 2'd0) ? 8'h00 : {4'b0000, 1'b1, lat_avg, 1'b0};
        end else begin
            unique case (cmd_idx)
                2'd0:    begin cmd.regsel = REG_CTRL_LO;  cmd.data = {1'b1, lat_acq, 5'b10101}; end
                2'd1:    begin cmd.regsel = REG_CTRL_LO;  cmd.data = {1'b0, lat_acq, 5'b10101}; end
                default: begin cmd.regsel = REG_READ_SEL; cmd.data = 8'h38; end
            endcase
        end
    end

    assign xfer_req_o = (state == S_CMD) || (state == S_READ);
    assign xfer_tx_o  = (state == S_READ) ? READBACK_FILL : build_cmd(cmd);
    assign busy_o     = (state != S_IDLE);
    assign done_o     = (state == S_FINISH);
    assign status_o   = status;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            status        <= ST_OK;
            cmd_idx       <= '0;
            frm           <= '0;
            cnt           <= '0;
            lat_disc      <= 1'b0;
            lat_extra     <= '0;
            lat_acq       <= '0;
            lat_avg       <= '0;
            frame_valid_o <= 1'b0;
            frame_data_o  <= '0;
            dev_found_o   <= '0;
        end else begin
            frame_valid_o <= 1'b0;
            unique case (state)
                S_IDLE: if (start_i) begin
                    lat_disc  <= discover_i;
                    lat_extra <= extra_dev_i;
                    lat_acq   <= acq_code_i;
                    lat_avg   <= avg_code_i;
                    status    <= ST_OK;
                    cmd_idx   <= '0;
                    frm       <= '0;
                    state     <= S_CMD;
                end
                S_CMD: if (xfer_done_i) begin
                    if (cmd_idx == last_cmd) begin
                        if (lat_disc) state <= S_READ;
                        else begin
                            cnt   <= wait_cycles - CNT_W'(1);
                            state <= S_WAIT;
                        end
                    end else cmd_idx <= cmd_idx + 2'd1;
                end
                S_WAIT: begin
                    if (cnt == '0) state <= S_READ;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                S_READ: if (xfer_done_i) begin
                    if (!lat_disc) begin
                        if (!crc_ok) begin
                            status <= ST_CRC;
                            state  <= S_FINISH;
                        end else begin
                            frame_valid_o <= 1'b1;
                            frame_data_o  <= xfer_rx_i;
                            if (frm == last_frm) state <= S_FINISH;
                            else                 frm   <= frm + FRM_W'(1);
                        end
                    end else if (is_zero) begin
                        if (frm == '0) status <= ST_CHAIN;
                        else           dev_found_o <= DEV_W'(frm - FRM_W'(1));
                        state <= S_FINISH;
                    end else if (!crc_ok) begin
                        status <= ST_CRC;
                        state  <= S_FINISH;
                    end else if (!addr_ok) begin
                        status <= ST_ADDR;
                        state  <= S_FINISH;
                    end else if (frm == FRM_W'(MAX_DEV)) begin
                        status <= ST_CHAIN;
                        state  <= S_FINISH;
                    end else frm <= frm + FRM_W'(1);
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer_req_o && !xfer_done_i) |=> xfer_req_o && $stable(xfer_tx_o));

    a_r3_wait_countdown: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && cnt != '0) |=> state == S_WAIT && cnt == $past(cnt) - CNT_W'(1));

    a_r5_crc_abort: assert property (@(posedge clk) disable iff (rst)
        (state == S_READ && xfer_done_i && !is_zero && !crc_ok) |=> !xfer_req_o && status_o == ST_CRC && !frame_valid_o);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(lat_disc) && $stable(lat_extra) && $stable(lat_avg));

    a_r6_no_forward_discovery: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |-> !lat_disc);

endmodule

// File: tb/chain_scan_seq_test.sv
module chain_scan_seq_test;
    localparam int CLK_MHZ = 2;
    localparam int LAT     = 2;

    logic clk = 0, rst = 1;
    logic start_i = 0, discover_i = 0;
    logic [2:0] extra_dev_i = 0;
    logic [1:0] acq_code_i = 0, avg_code_i = 0;
    logic xfer_req_o, xfer_done_i = 0;
    logic [31:0] xfer_tx_o, xfer_rx_i = 0;
    logic frame_valid_o, busy_o, done_o;
    logic [31:0] frame_data_o;
    logic [1:0] status_o;
    logic [2:0] dev_found_o;

    chain_scan_seq #(.CLK_MHZ(CLK_MHZ)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .discover_i(discover_i),
        .extra_dev_i(extra_dev_i), .acq_code_i(acq_code_i), .avg_code_i(avg_code_i),
        .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o), .xfer_done_i(xfer_done_i),
        .xfer_rx_i(xfer_rx_i), .frame_valid_o(frame_valid_o), .frame_data_o(frame_data_o),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .dev_found_o(dev_found_o)
    );

    always #5 clk = ~clk;

    int cyc = 0, tests = 0, fails = 0, done_cnt = 0;
    logic prev_done = 0;
    logic [31:0] rx_q[$], tx_w[$], fv_q[$];
    int tx_cyc[$], dn_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bcrc(input int v);
        int r = v;
        for (int b = 23; b >= 8; b--)
            if ((r >> b) & 1) r = r ^ (32'h12F << (b - 8));
        return r & 8'hFF;
    endfunction

    function automatic logic [31:0] exp_cmd(input int regsel, input int data);
        int w = (regsel << 21) | (data << 13) | (1 << 12);
        return 32'(w | (bcrc(w >>> 11) << 3) | 2);
    endfunction

    function automatic logic [31:0] rx_frame(input int payload, input bit corrupt);
        int p = payload & 32'h3FFFFF;
        int c = bcrc(p) ^ (corrupt ? 1 : 0);
        return 32'((p << 10) | (c << 2));
    endfunction

    function automatic int rev5b(input int a);
        return ((a & 1) << 4) | ((a & 2) << 2) | (a & 4) | ((a & 8) >> 2) | ((a & 16) >> 4);
    endfunction

    function automatic int exp_delay(input int acq, input int avg, input int extra);
        int ta[4] = '{465, 1010, 1460, 1890};
        int ns = (ta[acq] + 695) * 12 * (1 << avg) - ta[acq] + extra * 250;
        return ((ns + 999) / 1000 + 5) * CLK_MHZ;
    endfunction

    // PHY model: serves requests from the rx queue.
    initial begin
        forever begin
            @(negedge clk);
            while (xfer_req_o) begin
                tx_w.push_back(xfer_tx_o);
                tx_cyc.push_back(cyc);
                repeat (LAT) @(negedge clk);
                xfer_rx_i   = (rx_q.size() > 0) ? rx_q.pop_front() : 32'h0;
                xfer_done_i = 1;
                dn_cyc.push_back(cyc);
                @(negedge clk);
                xfer_done_i = 0;
            end
        end
    end

    // Per-clock monitor against the behavioural rules.
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid_o) fv_q.push_back(frame_data_o);
            if (done_o) done_cnt++;
            if (done_o && prev_done) begin
                fails++; $display("FAIL R9 done high two cycles actual=1 expected=0");
            end
            if (xfer_req_o && !busy_o) begin
                fails++; $display("FAIL R9 request while idle actual=1 expected=0");
            end
            prev_done = done_o;
        end
    end

    task automatic run(input bit disc, input int extra, input int acq, input int avg, input bit poke);
        tx_w.delete(); tx_cyc.delete(); dn_cyc.delete(); fv_q.delete(); done_cnt = 0;
        @(negedge clk);
        discover_i = disc; extra_dev_i = 3'(extra); acq_code_i = 2'(acq); avg_code_i = 2'(avg);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        if (poke) begin
            repeat (12) @(negedge clk);
            discover_i = ~disc; extra_dev_i = 3'(extra + 1); start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic scan_test(input int extra, input int acq, input int avg, input int bad, input bit poke);
        int nfr = (extra + 1) * 12;
        int nrd = (bad >= 0) ? bad + 1 : nfr;
        logic [31:0] exp_fr[$];
        bit ok;
        rx_q.delete();
        rx_q.push_back(0); rx_q.push_back(0);
        for (int k = 0; k < nfr; k++) begin
            exp_fr.push_back(rx_frame(k * 37 + extra * 5 + 1, 0));
            rx_q.push_back(rx_frame(k * 37 + extra * 5 + 1, k == bad));
        end
        run(0, extra, acq, avg, poke);
        check(tx_w.size() == 2 + nrd, "R4 transfer count", tx_w.size(), 2 + nrd);
        check(tx_w[0] == exp_cmd(6'h1C, 0), "R2 read-select cmd", tx_w[0], exp_cmd(6'h1C, 0));
        check(tx_w[1] == exp_cmd(6'h0D, 8'h08 | (avg << 1)), "R2 control cmd",
              tx_w[1], exp_cmd(6'h0D, 8'h08 | (avg << 1)));
        check(tx_cyc[2] - dn_cyc[1] == exp_delay(acq, avg, extra) + 1, "R3 wait delay",
              tx_cyc[2] - dn_cyc[1], exp_delay(acq, avg, extra) + 1);
        ok = 1;
        for (int k = 2; k < tx_w.size(); k++) if (tx_w[k] != 32'hF800030A) ok = 0;
        check(ok, "R4 filler word", 0, 32'hF800030A);
        check(fv_q.size() == ((bad >= 0) ? bad : nfr), "R4 frames forwarded", fv_q.size(),
              (bad >= 0) ? bad : nfr);
        ok = 1;
        foreach (fv_q[k]) if (fv_q[k] != exp_fr[k]) ok = 0;
        check(ok, "R4 frame data", 0, 0);
        check(status_o == ((bad >= 0) ? 2'd1 : 2'd0), "R5 status", status_o, (bad >= 0) ? 1 : 0);
        check(done_cnt == 1 && !busy_o, "R9 one done pulse", done_cnt, 1);
    endtask

    task automatic disc_test(input int acq, input int nvalid, input int badaddr,
                             input int exp_st, input int exp_found);
        rx_q.delete();
        rx_q.push_back(0); rx_q.push_back(0); rx_q.push_back(0);
        for (int k = 0; k < nvalid; k++) begin
            int a = (k == badaddr) ? k + 1 : k;
            rx_q.push_back(rx_frame((rev5b(a) << 17) | (8'h0E << 11) | k, 0));
        end
        rx_q.push_back(0);
        run(1, 0, acq, 0, 0);
        check(tx_w[0] == exp_cmd(6'h0E, 8'h95 | (acq << 5)), "R6 reset cmd",
              tx_w[0], exp_cmd(6'h0E, 8'h95 | (acq << 5)));
        check(tx_w[1] == exp_cmd(6'h0E, 8'h15 | (acq << 5)), "R6 lock cmd",
              tx_w[1], exp_cmd(6'h0E, 8'h15 | (acq << 5)));
        check(tx_w[2] == exp_cmd(6'h1C, 8'h38), "R6 select cmd", tx_w[2], exp_cmd(6'h1C, 8'h38));
        check(tx_cyc[3] - dn_cyc[2] == 1, "R6 no wait", tx_cyc[3] - dn_cyc[2], 1);
        check(fv_q.size() == 0, "R6 nothing forwarded", fv_q.size(), 0);
        check(status_o == 2'(exp_st), "R7 status", status_o, exp_st);
        if (exp_st == 0) check(dev_found_o == 3'(exp_found), "R7 count", dev_found_o, exp_found);
        check(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!xfer_req_o && !busy_o && !done_o && !frame_valid_o, "R1 idle outputs", busy_o, 0);
        check(status_o == 0 && dev_found_o == 0, "R1 status", status_o, 0);
        scan_test(0, 0, 0, -1, 0);
        scan_test(2, 2, 1, -1, 1);       // R8: second start during the wait
        scan_test(1, 1, 2, 5, 0);        // R5: corrupt CRC on frame 5
        scan_test(7, 3, 3, -1, 0);
        disc_test(1, 3, -1, 0, 2);       // R7: three devices
        disc_test(2, 4, 2, 2, 0);        // R7: address mismatch
        disc_test(0, 0, -1, 3, 0);       // R7: zero at index 0
        disc_test(3, 9, -1, 3, 0);       // R7: no terminator
        check(tx_w.size() == 12, "R7 nine reads", tx_w.size(), 12);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule